// File: doc/BRIEF.md
# Gate Array I/O Decoder with Memory Paging

This block sits between a CPU's I/O cycles and two peripherals, the video gate array and the video timing controller. Each I/O access carries a 16-bit address, a data byte and a read or write strobe. From the address the block decides which devices take part. It merges the read data of every device that answers. It also keeps the gate array's state: the palette pen, the last colour written, the next video mode, the two ROM enables and the bank number of each of the four 16 KiB CPU windows.

Neither the gate array nor the timing controller looks at the direction of the cycle. A read cycle that decodes to one of them still makes it act, and the byte it acts on is whatever the other devices put on the bus. The block models this directly. During a read, the byte the devices see is the AND of all responders, and it is `FF` when nothing answers.

A RAM configuration command selects one of eight fixed bank layouts. The block only honours it when 128K operation is enabled. The ROM enables are outputs for the memory mapper. A mapped ROM replaces reads only, and writes always go to the RAM bank of that window.

Top module: `ga_io_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bank_map` is `0x688` (windows 0..3 hold banks 0,1,2,3). `lower_rom_en` and `upper_rom_en` are 1. `vid_mode`, `pen_idx`, `colour_val`, `colour_we` and `irq_cnt_rst` are 0. `io_rdata` is `FF`.
- R2: The gate array takes part only when address bits 15:14 are `01`. Bits 7:6 of the cycle byte pick the command: 0 pen, 1 colour, 2 ROM/mode, 3 RAM layout. The pen command stores bits 4:0 in `pen_idx`. Registered outputs change only at the clock edge that ends an access cycle.
- R3: The colour command stores bits 4:0 in `colour_val` and raises `colour_we` for exactly one cycle after the access.
- R4: The ROM/mode command clears `lower_rom_en` when bit 2 is set and clears `upper_rom_en` when bit 3 is set. It loads bits 1:0 into `vid_mode`.
- R5: The ROM/mode command with bit 4 set raises `irq_cnt_rst` for exactly one cycle after the access.
- R6: The RAM layout command uses bits 2:0 as the code. Each window i occupies `bank_map[3i+2:3i]`. The codes give these banks for windows 0..3: 0→0,1,2,3; 1→0,1,2,7; 2→4,5,6,7; 3→0,3,2,7; 4→0,4,2,3; 5→0,5,2,3; 6→0,6,2,3; 7→0,7,2,3.
- R7: With `en_128k` low, a RAM layout command leaves `bank_map` unchanged.
- R8: On a read cycle that selects the gate array, the command byte is the merged read data, and the gate array acts on it.
- R9: The timing-controller strobes need address bit 14 = 0 and use bits 9:8 as the action code. Code 0 raises `crtc_sel` and code 1 raises `crtc_wr`, on reads and writes alike. Code 2 raises `crtc_rd_status` and code 3 raises `crtc_rd_reg`, on reads only. The strobes are combinational within the access cycle, at most one is high, and `crtc_data` carries the cycle byte.
- R10: `io_rdata` starts at `FF` and is ANDed with each responder on a read. The responders are: `pio_rdata` when address bit 11 is 0; `fdc_rdata` when `fdc_fitted` is high and (address AND `0x580`) equals `0x100`; `crtc_status` on action code 2; `crtc_regdata` on action code 3. Outside a read it is `FF`.
- R11: When `io_rd` and `io_wr` are both high, the cycle is a write. The cycle byte is `io_wdata` and `io_rdata` stays `FF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current cycle |
| io_wdata | input | 8 | CPU write byte |
| io_rd | input | 1 | I/O read strobe, one cycle per access |
| io_wr | input | 1 | I/O write strobe, one cycle per access |
| en_128k | input | 1 | Allows RAM layout commands |
| fdc_fitted | input | 1 | Disk controller is present |
| pio_rdata | input | 8 | Parallel port read byte |
| fdc_rdata | input | 8 | Disk controller read byte |
| crtc_status | input | 8 | Timing-controller status byte |
| crtc_regdata | input | 8 | Timing-controller register byte |
| io_rdata | output | 8 | Merged read data |
| crtc_sel | output | 1 | Register-select strobe |
| crtc_wr | output | 1 | Register-write strobe |
| crtc_rd_status | output | 1 | Status-read strobe |
| crtc_rd_reg | output | 1 | Register-read strobe |
| crtc_data | output | 8 | Byte offered to the timing controller |
| pen_idx | output | 5 | Selected palette pen |
| colour_val | output | 5 | Last colour written |
| colour_we | output | 1 | One-cycle colour update pulse |
| vid_mode | output | 2 | Posted next video mode |
| lower_rom_en | output | 1 | Lower ROM mapped for reads |
| upper_rom_en | output | 1 | Upper ROM mapped for reads |
| irq_cnt_rst | output | 1 | One-cycle interrupt-counter reset |
| bank_map | output | 12 | Bank number of each CPU window, 3 bits each |

## Verification
Some properties can be checked on every cycle, and the assertions cover those. At most one timing-controller strobe is high at a time, and any strobe needs bit 14 low and an active cycle. The bank map is frozen while 128K operation is off, and no registered state moves on an idle cycle. The colour and interrupt-reset pulses only follow a gate-array access, and the read bus idles at `FF`. Other behaviour depends on particular bytes and addresses, and only the bench's directed scenarios can show it. These are the eight layout codes, the ROM-enable polarity, the AND of several responders, and a read cycle steering the gate array with whatever byte the port or the disk controller returned.

// File: rtl/ga_pkg.sv
package ga_pkg;

    localparam int PEN_W   = 5;
    localparam int MODE_W  = 2;
    localparam int BANK_W  = 3;
    localparam int WINDOWS = 4;
    localparam int MAP_W   = BANK_W * WINDOWS;

    typedef enum logic [1:0] {
        GA_PEN    = 2'd0,
        GA_COLOUR = 2'd1,
        GA_ROMCTL = 2'd2,
        GA_RAMCFG = 2'd3
    } ga_func_e;

    typedef enum logic [1:0] {
        CR_SELECT  = 2'd0,
        CR_WRITE   = 2'd1,
        CR_STATUS  = 2'd2,
        CR_READREG = 2'd3
    } crtc_act_e;

    typedef struct packed {
        ga_func_e    func;
        logic [5:0]  arg;
    } ga_cmd_t;

    typedef logic [BANK_W-1:0] bank_t;
    typedef bank_t [WINDOWS-1:0] layout_t;

    // Window 0 is the lowest element of the packed array
    function automatic layout_t layout_of(input logic [2:0] code);
        layout_t l;
        case (code)
            3'd0:    l = {3'd3, 3'd2, 3'd1, 3'd0};
            3'd1:    l = {3'd7, 3'd2, 3'd1, 3'd0};
            3'd2:    l = {3'd7, 3'd6, 3'd5, 3'd4};
            3'd3:    l = {3'd7, 3'd2, 3'd3, 3'd0};
            default: l = {3'd3, 3'd2, code, 3'd0};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/ga_crtc_strobe.sv
module ga_crtc_strobe #(
    parameter int ADDR_W   = 16,
    parameter int SEL_BIT  = 14,
    parameter int CODE_LSB = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              acc,
    input  logic              rd_only,
    output logic              sel,
    output logic              wr,
    output logic              rd_status,
    output logic              rd_reg
);
    import ga_pkg::*;

    crtc_act_e act;
    logic      hit;

    always_comb begin
        act       = crtc_act_e'(addr[CODE_LSB +: 2]);
        hit       = acc && !addr[SEL_BIT];
        sel       = hit && (act == CR_SELECT);
        wr        = hit && (act == CR_WRITE);
        rd_status = hit && rd_only && (act == CR_STATUS);
        rd_reg    = hit && rd_only && (act == CR_READREG);
    end
endmodule

// File: rtl/ga_bus_merge.sv
module ga_bus_merge #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                PIO_BIT   = 11,
    parameter logic [ADDR_W-1:0] FDC_MASK  = 16'h0580,
    parameter logic [ADDR_W-1:0] FDC_MATCH = 16'h0100
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_only,
    input  logic              fdc_fitted,
    input  logic              status_rd,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] pio_rdata,
    input  logic [DATA_W-1:0] fdc_rdata,
    input  logic [DATA_W-1:0] crtc_status,
    input  logic [DATA_W-1:0] crtc_regdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int NSRC = 4;

    logic [NSRC-1:0]             resp;
    logic [NSRC-1:0][DATA_W-1:0] src;

    always_comb begin
        resp[0] = !addr[PIO_BIT];
        resp[1] = fdc_fitted && ((addr & FDC_MASK) == FDC_MATCH);
        resp[2] = status_rd;
        resp[3] = reg_rd;
        src[0]  = pio_rdata;
        src[1]  = fdc_rdata;
        src[2]  = crtc_status;
        src[3]  = crtc_regdata;
    end

    logic [NSRC:0][DATA_W-1:0] chain;
    assign chain[0] = '1;

    for (genvar i = 0; i < NSRC; i++) begin : g_and
        assign chain[i+1] = (rd_only && resp[i]) ? (chain[i] & src[i]) : chain[i];
    end

    assign rdata = chain[NSRC];
endmodule

// File: rtl/ga_ctrl_regs.sv
module ga_ctrl_regs #(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hit,
    input  logic [DATA_W-1:0]        cyc_data,
    input  logic                     en_128k,
    output logic [ga_pkg::PEN_W-1:0] pen_idx,
    output logic [ga_pkg::PEN_W-1:0] colour_val,
    output logic                     colour_we,
    output logic [ga_pkg::MODE_W-1:0] vid_mode,
    output logic                     lower_rom_en,
    output logic                     upper_rom_en,
    output logic                     irq_cnt_rst,
    output ga_pkg::layout_t          banks
);
    import ga_pkg::*;

    ga_cmd_t cmd;
    logic    lo_off, hi_off;

    assign cmd          = ga_cmd_t'(cyc_data[7:0]);
    assign lower_rom_en = !lo_off;
    assign upper_rom_en = !hi_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            pen_idx     <= '0;
            colour_val  <= '0;
            colour_we   <= 1'b0;
            vid_mode    <= '0;
            lo_off      <= 1'b0;
            hi_off      <= 1'b0;
            irq_cnt_rst <= 1'b0;
            banks       <= layout_of(3'd0);
        end else begin
            colour_we   <= 1'b0;
            irq_cnt_rst <= 1'b0;
            if (hit) begin
                case (cmd.func)
                    GA_PEN:    pen_idx <= cmd.arg[PEN_W-1:0];
                    GA_COLOUR: begin
                        colour_val <= cmd.arg[PEN_W-1:0];
                        colour_we  <= 1'b1;
                    end
                    GA_ROMCTL: begin
                        lo_off      <= cmd.arg[2];
                        hi_off      <= cmd.arg[3];
                        irq_cnt_rst <= cmd.arg[4];
                        vid_mode    <= cmd.arg[MODE_W-1:0];
                    end
                    GA_RAMCFG: if (en_128k) banks <= layout_of(cmd.arg[2:0]);
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ga_io_decoder.sv
module ga_io_decoder #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          PIO_BIT   = 11,
    parameter int          CRTC_BIT  = 14,
    parameter logic [15:0] FDC_MASK  = 16'h0580,
    parameter logic [15:0] FDC_MATCH = 16'h0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              en_128k,
    input  logic              fdc_fitted,
    input  logic [DATA_W-1:0] pio_rdata,
    input  logic [DATA_W-1:0] fdc_rdata,
    input  logic [DATA_W-1:0] crtc_status,
    input  logic [DATA_W-1:0] crtc_regdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              crtc_sel,
    output logic              crtc_wr,
    output logic              crtc_rd_status,
    output logic              crtc_rd_reg,
    output logic [DATA_W-1:0] crtc_data,
    output logic [4:0]        pen_idx,
    output logic [4:0]        colour_val,
    output logic              colour_we,
    output logic [1:0]        vid_mode,
    output logic              lower_rom_en,
    output logic              upper_rom_en,
    output logic              irq_cnt_rst,
    output logic [11:0]       bank_map
);
    import ga_pkg::*;

    logic              acc, rd_only, ga_hit;
    logic [DATA_W-1:0] merged, cyc_data;
    layout_t           banks;

    assign acc      = io_rd || io_wr;
    assign rd_only  = io_rd && !io_wr;
    assign ga_hit   = acc && (io_addr[ADDR_W-1 -: 2] == 2'b01);
    assign cyc_data = io_wr ? io_wdata : merged;
    assign io_rdata = merged;
    assign crtc_data = cyc_data;
    assign bank_map = banks;

    ga_crtc_strobe #(.ADDR_W(ADDR_W), .SEL_BIT(CRTC_BIT), .CODE_LSB(8)) u_strobe (
        .addr      (io_addr),
        .acc       (acc),
        .rd_only   (rd_only),
        .sel       (crtc_sel),
        .wr        (crtc_wr),
        .rd_status (crtc_rd_status),
        .rd_reg    (crtc_rd_reg)
    );

    ga_bus_merge #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIO_BIT(PIO_BIT),
        .FDC_MASK(FDC_MASK), .FDC_MATCH(FDC_MATCH)
    ) u_merge (
        .addr         (io_addr),
        .rd_only      (rd_only),
        .fdc_fitted   (fdc_fitted),
        .status_rd    (crtc_rd_status),
        .reg_rd       (crtc_rd_reg),
        .pio_rdata    (pio_rdata),
        .fdc_rdata    (fdc_rdata),
        .crtc_status  (crtc_status),
        .crtc_regdata (crtc_regdata),
        .rdata        (merged)
    );

    ga_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .hit          (ga_hit),
        .cyc_data     (cyc_data),
        .en_128k      (en_128k),
        .pen_idx      (pen_idx),
        .colour_val   (colour_val),
        .colour_we    (colour_we),
        .vid_mode     (vid_mode),
        .lower_rom_en (lower_rom_en),
        .upper_rom_en (upper_rom_en),
        .irq_cnt_rst  (irq_cnt_rst),
        .banks        (banks)
    );
endmodule

// File: rtl/ga_io_decoder_chk.sv
module ga_io_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] io_addr,
    input logic        io_rd,
    input logic        io_wr,
    input logic        en_128k,
    input logic [7:0]  io_rdata,
    input logic        crtc_sel,
    input logic        crtc_wr,
    input logic        crtc_rd_status,
    input logic        crtc_rd_reg,
    input logic [4:0]  pen_idx,
    input logic        colour_we,
    input logic [1:0]  vid_mode,
    input logic        irq_cnt_rst,
    input logic [11:0] bank_map
);
    logic any_strobe;
    assign any_strobe = crtc_sel || crtc_wr || crtc_rd_status || crtc_rd_reg;

    AST_CRTC_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({crtc_sel, crtc_wr, crtc_rd_status, crtc_rd_reg})); // R9

    AST_CRTC_NEEDS_A14_LOW: assert property (@(posedge clk) disable iff (rst)
        any_strobe |-> (!io_addr[14] && (io_rd || io_wr))); // R9

    AST_BANKS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !en_128k |=> (bank_map == $past(bank_map))); // R7

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
        !(io_rd || io_wr) |=> ($stable(bank_map) && $stable(vid_mode) && $stable(pen_idx))); // R2

    AST_IRQ_AFTER_GA_ACCESS: assert property (@(posedge clk) disable iff (rst)
        irq_cnt_rst |-> $past((io_rd || io_wr) && io_addr[15:14] == 2'b01)); // R5

    AST_COLOUR_AFTER_GA_ACCESS: assert property (@(posedge clk) disable iff (rst)
        colour_we |-> $past((io_rd || io_wr) && io_addr[15:14] == 2'b01)); // R3

    AST_RDATA_IDLE_FF: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && !io_wr) |-> (io_rdata == 8'hFF)); // R10
endmodule

bind ga_io_decoder ga_io_decoder_chk u_chk (.*);

// File: tb/ga_io_decoder_test.sv
module ga_io_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic        en_128k = 1'b0, fdc_fitted = 1'b0;
    logic [7:0]  pio_rdata = '0, fdc_rdata = '0, crtc_status = '0, crtc_regdata = '0;
    logic [7:0]  io_rdata, crtc_data;
    logic        crtc_sel, crtc_wr, crtc_rd_status, crtc_rd_reg;
    logic [4:0]  pen_idx, colour_val;
    logic        colour_we, lower_rom_en, upper_rom_en, irq_cnt_rst;
    logic [1:0]  vid_mode;
    logic [11:0] bank_map;

    int checks = 0, failures = 0;
    logic [7:0] c_rdata, c_data;
    logic [3:0] c_strb;

    always #4 clk = ~clk;

    ga_io_decoder uut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access cycle; combinational outputs captured mid-cycle
    task automatic access(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
        #1;
        c_rdata = io_rdata; c_data = crtc_data;
        c_strb = {crtc_sel, crtc_wr, crtc_rd_status, crtc_rd_reg};
        @(posedge clk); #1;
        io_rd = 0; io_wr = 0; io_addr = 16'hFFFF;
    endtask

    function automatic logic [11:0] lay(input int w0, input int w1, input int w2, input int w3);
        return {w3[2:0], w2[2:0], w1[2:0], w0[2:0]};
    endfunction

    task automatic t_reset();
        rst = 1; repeat (3) @(posedge clk); #1; rst = 0;
        check("R1 banks", bank_map, 12'h688);
        check("R1 roms", {lower_rom_en, upper_rom_en}, 2'b11);
        check("R1 mode/pen/colour", {vid_mode, pen_idx, colour_val}, 0);
        check("R1 pulses", {colour_we, irq_cnt_rst}, 0);
        check("R1 rdata", io_rdata, 8'hFF);
    endtask

    task automatic t_pen_colour();
        access(0, 1, 16'h7F00, 8'h13);
        check("R2 pen", pen_idx, 5'h13);
        access(0, 1, 16'h7F00, 8'h5A);
        check("R3 colour", colour_val, 5'h1A);
        check("R3 pulse high", colour_we, 1);
        @(posedge clk); #1;
        check("R3 pulse one cycle", colour_we, 0);
        access(0, 1, 16'h8F00, 8'h07);
        check("R2 not selected at 10", pen_idx, 5'h13);
    endtask

    task automatic t_rom_mode();
        access(0, 1, 16'h7F00, 8'h9F);
        check("R4 roms off", {lower_rom_en, upper_rom_en}, 2'b00);
        check("R4 mode 3", vid_mode, 2'd3);
        check("R5 irq high", irq_cnt_rst, 1);
        @(posedge clk); #1;
        check("R5 irq one cycle", irq_cnt_rst, 0);
        access(0, 1, 16'h7F00, 8'h81);
        check("R4 roms on", {lower_rom_en, upper_rom_en}, 2'b11);
        check("R4 mode 1", vid_mode, 2'd1);
        check("R5 irq stays low", irq_cnt_rst, 0);
        access(0, 1, 16'h7F00, 8'h84);
        check("R4 lower only off", {lower_rom_en, upper_rom_en}, 2'b01);
    endtask

    task automatic t_ram();
        logic [11:0] exp [8];
        exp[0] = lay(0,1,2,3); exp[1] = lay(0,1,2,7); exp[2] = lay(4,5,6,7);
        exp[3] = lay(0,3,2,7); exp[4] = lay(0,4,2,3); exp[5] = lay(0,5,2,3);
        exp[6] = lay(0,6,2,3); exp[7] = lay(0,7,2,3);
        en_128k = 1;
        for (int i = 7; i >= 0; i--) begin
            access(0, 1, 16'h7F00, 8'hC0 | 8'(i));
            check($sformatf("R6 layout %0d", i), bank_map, exp[i]);
        end
        access(0, 1, 16'h7F00, 8'hC3);
        en_128k = 0;
        access(0, 1, 16'h7F00, 8'hC2);
        check("R7 locked", bank_map, exp[3]);
        en_128k = 1;
        access(0, 1, 16'h7F00, 8'hC0);
        check("R7 unlocked again", bank_map, exp[0]);
    endtask

    task automatic t_read_sample();
        pio_rdata = 8'h8A;
        access(1, 0, 16'h7700, 8'h00);
        check("R8 rdata from port", c_rdata, 8'h8A);
        check("R8 roms from read", {lower_rom_en, upper_rom_en}, 2'b10);
        check("R8 mode from read", vid_mode, 2'd2);
        access(1, 0, 16'h7F00, 8'h00);
        check("R8 idle bus FF picks layout 7", bank_map, lay(0,7,2,3));
    endtask

    task automatic t_merge();
        fdc_rdata = 8'h5C; fdc_fitted = 1;
        access(1, 0, 16'hFB7F, 8'h00);
        check("R10 fdc fitted", c_rdata, 8'h5C);
        fdc_fitted = 0;
        access(1, 0, 16'hFB7F, 8'h00);
        check("R10 fdc absent", c_rdata, 8'hFF);
        fdc_fitted = 1; pio_rdata = 8'hF3; fdc_rdata = 8'h3C;
        access(1, 0, 16'hC100, 8'h00);
        check("R10 and of two", c_rdata, 8'h30);
        @(negedge clk);
        check("R10 idle FF", io_rdata, 8'hFF);
    endtask

    task automatic t_crtc();
        crtc_status = 8'hA5; crtc_regdata = 8'h3C;
        access(0, 1, 16'hBC00, 8'h0C);
        check("R9 select strobe", c_strb, 4'b1000);
        check("R9 data", c_data, 8'h0C);
        access(0, 1, 16'hBD00, 8'h55);
        check("R9 write strobe", c_strb, 4'b0100);
        access(1, 0, 16'hBE00, 8'h00);
        check("R9 status strobe", c_strb, 4'b0010);
        check("R10 status data", c_rdata, 8'hA5);
        access(1, 0, 16'hBF00, 8'h00);
        check("R9 reg strobe", c_strb, 4'b0001);
        check("R10 reg data", c_rdata, 8'h3C);
        access(1, 0, 16'hBC00, 8'h00);
        check("R9 select on read", c_strb, 4'b1000);
        check("R9 read bus byte", c_data, 8'hFF);
        access(0, 1, 16'hBE00, 8'h00);
        check("R9 status not on write", c_strb, 4'b0000);
    endtask

    task automatic t_both();
        pio_rdata = 8'h00;
        access(1, 1, 16'h7F00, 8'h51);
        check("R11 write wins", colour_val, 5'h11);
        check("R11 rdata FF", c_rdata, 8'hFF);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_pen_colour();
        t_rom_mode();
        t_ram();
        t_read_sample();
        t_merge();
        t_crtc();
        t_both();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule